// File: doc/BRIEF.md
# Two-Stage Crosspoint Switch Controller

This block is the digital control for a 4-by-8 analog switching matrix of 32 nodes. A host addresses one node at a time with a column select and a row select. It places an open or close request in a pending register with a load strobe. A separate transfer strobe then commits the whole pending register to the active register at once. While the transfer strobe is held low, the active register tracks the pending register continuously, so each single-node write takes effect without a separate commit.

The host reads back the active state of any node through a data output with an enable, which stands in for a bidirectional pin. An asynchronous, active-low master reset clears both registers, and therefore opens every node. Every control input is brought into the clock domain through a two-flop synchronizer, and the strobes act on their falling edges.

The active register does not drive the switches directly. A sequencer sits in between. On each change it first opens every node that must open. It closes the newly requested nodes only after a parameterised gap of `BBM_CYCLES` clocks. If the target changes again during that gap, the sequencer opens any node that the new target drops, restarts the gap, and keeps every pending close waiting.

Top module: `xpt_ctrl`

## Requirements
- R1: While `mrst_n` is low, `switch_en`, the pending register and the active register are all zero, and `dout_en` is low.
- R2: Node index = `sel_x * 8 + sel_y`, so `switch_en[i]` is the node at column `i/8`, row `i%8`.
- R3: A falling edge of `ld_n` loads `din` into the addressed pending bit, provided `cs_n` is low and `rd_nwr` is 0. A value of 1 requests close and 0 requests open. The pending register changes on no other event.
- R4: While `xfer_n` is high, the active register and `switch_en` ignore writes to the pending register.
- R5: A falling edge of `xfer_n` copies all 32 pending bits into the active register in one cycle.
- R6: While `xfer_n` stays low, the active register follows the pending register every cycle.
- R7: When `cs_n` is low and `rd_nwr` is 1, `dout_en` is high and `dout` equals the active bit of the addressed node. In every other case `dout_en` is low.
- R8: A load strobe has no effect during a read (`rd_nwr`=1) or while `cs_n` is high.
- R9: When the active register changes, nodes that leave the target open in the next cycle. Nodes that join the target close exactly `BBM_CYCLES` cycles later. No node closes while any node scheduled to open is still closed.
- R10: If the active register changes while a close is still waiting, the sequencer opens the nodes dropped by the new target at once and restarts the `BBM_CYCLES` wait. No waiting close is applied early.
- R11: Reset acts asynchronously, regardless of `cs_n`, the address lines or `rd_nwr`.
- R12: Inputs pass through 2 synchronizing flops. In transparent mode, a close written with an `ld_n` fall first sampled at clock edge j appears on `switch_en` after edge j+4+`BBM_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_nwr | input | 1 | 1 = read active state, 0 = write pending state |
| ld_n | input | 1 | Pending-load strobe, acts on falling edge |
| xfer_n | input | 1 | Transfer strobe: falling edge commits, held low = transparent |
| sel_x | input | 2 | Column select (X0..X3) |
| sel_y | input | 3 | Row select (Y0..Y7) |
| din | input | 1 | Write data: 1 close, 0 open |
| dout | output | 1 | Readback of the addressed active bit |
| dout_en | output | 1 | High while a read is selected and `dout` is valid |
| switch_en | output | 32 | Sequenced switch enables, one per node |

## Verification
The bench targets these corner cases:

- **Writes with `xfer_n` high.** A design that left the active register transparent would change `switch_en` at once.
- **Load strobes during a read or with `cs_n` high.** A design that did not qualify the strobe would later close the addressed node.
- **An open and a close in the same transfer.** A design that applied both together would close a node while another node scheduled to open was still closed.
- **A second change arriving inside the gap.** A sequencer that kept its old timer would close the first request early. One that waited to open would leave a dropped node closed.
- **Reset with chip select and write asserted.** A design that gated reset would leave nodes closed.
- **Transparent-mode latency.** A close is timed edge by edge, which exposes a missing or extra synchronizer stage.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  // synchronized control bundle, all fields active as on the pins
  typedef struct packed {
    logic ld_n;
    logic xfer_n;
    logic cs_n;
    logic rd;
  } ctl_t;

  // node numbering: all rows of column 0 first, then column 1, ...
  function automatic int node_idx(int col, int row, int rows);
    return col * rows + row;
  endfunction

  // break phase: keep only nodes that are both closed now and wanted
  function automatic logic [63:0] break_of(logic [63:0] now_en, logic [63:0] want);
    return now_en & want;
  endfunction

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic m1, m2;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          m1 <= RST_VAL[i];
          m2 <= RST_VAL[i];
        end else begin
          m1 <= d[i];
          m2 <= m1;
        end
      end
      assign q[i] = m2;
    end
  endgenerate

endmodule

// File: rtl/xpt_stages.sv
module xpt_stages #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_evt,
  input  logic          xfer_open,
  input  logic [IW-1:0] idx,
  input  logic          din,
  output logic [N-1:0]  pending,
  output logic [N-1:0]  active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else if (ld_evt) begin
      pending[idx] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (xfer_open) begin
      active <= pending;
    end
  end

endmodule

// File: rtl/xpt_bbm.sv
module xpt_bbm #(
  parameter int N          = 32,
  parameter int BBM_CYCLES = 8,
  parameter int CW         = $clog2(BBM_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  active,
  output logic [N-1:0]  switch_en,
  output logic [N-1:0]  tgt,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] GAP = CW'(BBM_CYCLES);

  logic          retarget;
  logic [N-1:0]  brk;
  logic [63:0]   brk_w;

  assign retarget = (active != tgt);
  assign brk_w    = xpt_pkg::break_of(64'(switch_en), 64'(active));
  assign brk      = brk_w[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      switch_en <= '0;
      tgt       <= '0;
      cnt       <= '0;
    end else if (retarget) begin
      switch_en <= brk;
      tgt       <= active;
      cnt       <= GAP;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) switch_en <= tgt;
    end
  end

endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
  parameter int NX         = 4,
  parameter int NY         = 8,
  parameter int BBM_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  mrst_n,
  input  logic                  cs_n,
  input  logic                  rd_nwr,
  input  logic                  ld_n,
  input  logic                  xfer_n,
  input  logic [$clog2(NX)-1:0] sel_x,
  input  logic [$clog2(NY)-1:0] sel_y,
  input  logic                  din,
  output logic                  dout,
  output logic                  dout_en,
  output logic [NX*NY-1:0]      switch_en
);

  localparam int N  = NX * NY;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(BBM_CYCLES + 1);

  logic [3:0]        ctl_raw_s;
  xpt_pkg::ctl_t     ctl_s;
  logic              ld_prev;
  logic              ld_fall;
  logic              ld_evt;
  logic              xfer_open;
  logic              rd_sel;
  logic [IW-1:0]     idx;
  logic [N-1:0]      pending;
  logic [N-1:0]      active;
  logic [N-1:0]      tgt;
  logic [CW-1:0]     seq_cnt;

  xpt_sync #(.W(4), .RST_VAL(4'b1111)) u_sync (
    .clk   (clk),
    .rst_n (mrst_n),
    .d     ({ld_n, xfer_n, cs_n, rd_nwr}),
    .q     (ctl_raw_s)
  );

  assign ctl_s = xpt_pkg::ctl_t'(ctl_raw_s);

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) ld_prev <= 1'b1;
    else         ld_prev <= ctl_s.ld_n;
  end

  assign ld_fall   = ld_prev & ~ctl_s.ld_n;
  assign ld_evt    = ld_fall & ~ctl_s.cs_n & ~ctl_s.rd;
  assign xfer_open = ~ctl_s.xfer_n;
  assign rd_sel    = ~ctl_s.cs_n & ctl_s.rd;
  assign idx       = IW'(xpt_pkg::node_idx(int'(sel_x), int'(sel_y), NY));

  xpt_stages #(.N(N), .IW(IW)) u_stages (
    .clk       (clk),
    .rst_n     (mrst_n),
    .ld_evt    (ld_evt),
    .xfer_open (xfer_open),
    .idx       (idx),
    .din       (din),
    .pending   (pending),
    .active    (active)
  );

  xpt_bbm #(.N(N), .BBM_CYCLES(BBM_CYCLES), .CW(CW)) u_bbm (
    .clk       (clk),
    .rst_n     (mrst_n),
    .active    (active),
    .switch_en (switch_en),
    .tgt       (tgt),
    .cnt       (seq_cnt)
  );

  assign dout    = active[idx];
  assign dout_en = rd_sel;

endmodule

// File: rtl/xpt_ctrl_chk.sv
module xpt_ctrl_chk #(
  parameter int N          = 32,
  parameter int BBM_CYCLES = 8,
  parameter int CW         = $clog2(BBM_CYCLES + 1)
) (
  input logic          clk,
  input logic          mrst_n,
  input logic          ld_evt,
  input logic          xfer_open,
  input logic [N-1:0]  pending,
  input logic [N-1:0]  active,
  input logic [N-1:0]  tgt,
  input logic [CW-1:0] seq_cnt,
  input logic [N-1:0]  switch_en,
  input logic          dout_en
);

  // R1
  rst_open_chk: assert property (@(posedge clk)
    !mrst_n |-> (switch_en == '0 && pending == '0 && active == '0 && !dout_en));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !ld_evt |=> $stable(pending));

  // R4
  act_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !xfer_open |=> $stable(active));

  // R9
  make_full_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (|(switch_en & ~$past(switch_en))) |-> (switch_en == tgt));

  // R9
  wait_safe_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (seq_cnt != '0) |-> ((switch_en & ~tgt) == '0));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (tgt != $past(tgt)) |-> (seq_cnt == CW'(BBM_CYCLES)));

endmodule

bind xpt_ctrl xpt_ctrl_chk #(.N(NX*NY), .BBM_CYCLES(BBM_CYCLES)) u_chk (
  .clk       (clk),
  .mrst_n    (mrst_n),
  .ld_evt    (ld_evt),
  .xfer_open (xfer_open),
  .pending   (pending),
  .active    (active),
  .tgt       (tgt),
  .seq_cnt   (seq_cnt),
  .switch_en (switch_en),
  .dout_en   (dout_en)
);

// File: tb/xpt_ctrl_bench.sv
module xpt_ctrl_bench;

  localparam int NX  = 4;
  localparam int NY  = 8;
  localparam int N   = NX * NY;
  localparam int BBM = 10;

  logic         clk = 1'b0;
  logic         mrst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         rd_nwr = 1'b1;
  logic         ld_n = 1'b1;
  logic         xfer_n = 1'b1;
  logic [1:0]   sel_x = '0;
  logic [2:0]   sel_y = '0;
  logic         din = 1'b0;
  logic         dout;
  logic         dout_en;
  logic [N-1:0] switch_en;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  xpt_ctrl #(.NX(NX), .NY(NY), .BBM_CYCLES(BBM)) u_xpt_ctrl (
    .clk(clk), .mrst_n(mrst_n), .cs_n(cs_n), .rd_nwr(rd_nwr), .ld_n(ld_n),
    .xfer_n(xfer_n), .sel_x(sel_x), .sel_y(sel_y), .din(din),
    .dout(dout), .dout_en(dout_en), .switch_en(switch_en)
  );

  // ---------------- behavioural reference ----------------
  typedef struct packed { logic ld; logic xf; logic cs; logic rd; } smp_t;
  smp_t         hist [$];
  logic [N-1:0] m_pend, m_act, m_tgt, m_sw, prev_sw;
  int           m_wait;

  task automatic model_clear();
    m_pend = '0; m_act = '0; m_tgt = '0; m_sw = '0; m_wait = 0;
    hist.delete();
    for (int i = 0; i < 3; i++) hist.push_front(smp_t'(4'b1111));
  endtask

  initial model_clear();

  always @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      model_clear();
    end else begin
      // hist[0] = sample one edge ago, hist[1] two ago, hist[2] three ago
      if (m_act != m_tgt) begin
        m_sw = m_sw & m_act; m_tgt = m_act; m_wait = BBM;
      end else if (m_wait > 0) begin
        m_wait--;
        if (m_wait == 0) m_sw = m_tgt;
      end
      if (!hist[1].xf) m_act = m_pend;
      if (hist[2].ld && !hist[1].ld && !hist[1].cs && !hist[1].rd)
        m_pend[int'(sel_x) * NY + int'(sel_y)] = din;
      hist.push_front(smp_t'({ld_n, xfer_n, cs_n, rd_nwr}));
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    logic exp_oe;
    exp_oe = !hist[1].cs && hist[1].rd;
    checks++;
    if (switch_en !== m_sw) begin
      errors++;
      $display("FAIL %s switch_en actual=%h expected=%h", cur_req, switch_en, m_sw);
    end
    checks++;
    if (dout_en !== exp_oe) begin
      errors++;
      $display("FAIL R7 dout_en actual=%b expected=%b", dout_en, exp_oe);
    end
    if (exp_oe) begin
      checks++;
      if (dout !== m_act[int'(sel_x) * NY + int'(sel_y)]) begin
        errors++;
        $display("FAIL R7 dout actual=%b expected=%b", dout, m_act[int'(sel_x) * NY + int'(sel_y)]);
      end
    end
    // R9: a cycle that closes a node must already hold no node meant to open
    if (mrst_n && |(switch_en & ~prev_sw)) begin
      checks++;
      if ((switch_en & ~m_act) != '0) begin
        errors++;
        $display("FAIL R9 close while open pending actual=%h expected=%h", switch_en, m_act);
      end
    end
    prev_sw = switch_en;
  end

  // ---------------- helpers ----------------
  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int x, int y, logic d);
    sel_x = 2'(x); sel_y = 3'(y); din = d; cs_n = 0; rd_nwr = 0;
    tick(1); ld_n = 0; tick(3); ld_n = 1; tick(3); cs_n = 1; rd_nwr = 1;
  endtask

  task automatic commit();
    xfer_n = 0; tick(2); xfer_n = 1; tick(1);
  endtask

  task automatic rd_node(int x, int y, logic exp, string req);
    sel_x = 2'(x); sel_y = 3'(y); cs_n = 0; rd_nwr = 1;
    tick(3); #1;
    chk({req, " read enable"}, 64'(dout_en), 64'(1));
    chk({req, " read data"}, 64'(dout), 64'(exp));
    tick(1); cs_n = 1;
  endtask

  task automatic settle();
    tick(BBM + 8);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    int n;
    tick(4);
    cur_req = "R1";
    chk("R1 reset switch_en", 64'(switch_en), 64'(0));
    chk("R1 reset dout_en", 64'(dout_en), 64'(0));
    mrst_n = 1; tick(3);

    // R4: pending write does not reach outputs while xfer_n high
    cur_req = "R4";
    wr(2, 5, 1'b1);
    settle();
    chk("R4 hold", 64'(switch_en), 64'(0));
    rd_node(2, 5, 1'b0, "R7 active still open");

    // R5 / R2: commit, node 2*8+5 = 21
    cur_req = "R5";
    commit(); settle();
    chk("R5 R2 commit node21", 64'(switch_en), 64'(32'h0020_0000));
    rd_node(2, 5, 1'b1, "R7 active closed");

    // R9: open node 21 and close node 3 in one commit
    cur_req = "R9";
    wr(2, 5, 1'b0); wr(0, 3, 1'b1);
    commit();
    n = 0;
    while (switch_en[21] && n < 40) begin tick(1); n++; end
    chk("R9 close held after break", 64'(switch_en[3]), 64'(0));
    settle();
    chk("R9 final", 64'(switch_en), 64'(32'h0000_0008));

    // R8: strobes during read or with chip select high are ignored
    cur_req = "R8";
    sel_x = 3; sel_y = 7; din = 1; cs_n = 0; rd_nwr = 1;
    tick(1); ld_n = 0; tick(3); ld_n = 1; tick(3); cs_n = 1;
    sel_x = 3; sel_y = 6; din = 1; cs_n = 1; rd_nwr = 0;
    tick(1); ld_n = 0; tick(3); ld_n = 1; tick(3); rd_nwr = 1;
    commit(); settle();
    chk("R8 ignored strobes", 64'(switch_en), 64'(32'h0000_0008));
    rd_node(3, 7, 1'b0, "R8 node31 open");

    // R12 / R6: transparent latency for a close of node 9
    cur_req = "R6";
    xfer_n = 0; tick(4);
    sel_x = 1; sel_y = 1; din = 1; cs_n = 0; rd_nwr = 0;
    tick(1); ld_n = 0;
    n = 0;
    while (!switch_en[9] && n < 60) begin @(posedge clk); #1; n++; end
    chk("R12 transparent latency", 64'(n), 64'(5 + BBM));
    chk("R6 transparent result", 64'(switch_en), 64'(32'h0000_0208));
    ld_n = 1; tick(3); cs_n = 1; rd_nwr = 1; settle();

    // R10: second change inside the gap, still transparent
    cur_req = "R10";
    wr(0, 1, 1'b1);      // close node 1, make waits BBM cycles
    wr(0, 3, 1'b0);      // open node 3 before that make lands
    chk("R10 open applied", 64'(switch_en[3]), 64'(0));
    chk("R10 close still held", 64'(switch_en[1]), 64'(0));
    tick(4);
    chk("R10 close held past old gap", 64'(switch_en[1]), 64'(0));
    settle();
    chk("R10 final", 64'(switch_en), 64'(32'h0000_0202));
    xfer_n = 1; tick(3);

    // R11: reset with chip select and write asserted
    cur_req = "R11";
    sel_x = 0; sel_y = 1; din = 1; cs_n = 0; rd_nwr = 0;
    mrst_n = 0; #1;
    chk("R11 async clear", 64'(switch_en), 64'(0));
    tick(2); mrst_n = 1; cs_n = 1; rd_nwr = 1; tick(3);
    commit(); settle();
    chk("R11 pending cleared", 64'(switch_en), 64'(0));
    rd_node(1, 1, 1'b0, "R11 node9 open");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule